// File: doc/BRIEF.md
# Host-Paced Remote DMA Port Engine

This block moves bytes between a single-byte host data port and a packet buffer memory held inside the block. The buffer is addressed in 256-byte pages. The host first programs three things through a small byte-wide register file: a 16-bit start address, a 16-bit byte count and a transfer mode. After that, each strobe on the data port moves exactly one byte. A read strobe fetches the byte at the current address. A write strobe stores a byte there. After each byte moves, the address steps forward and the remaining count steps down.

Transfers are paced entirely by the host. The engine never moves a byte on its own. When the remaining count reaches zero, a completion flag is raised in the status register. The flag stays set until the host writes a one to its bit. Strobes issued while no transfer is armed are ignored, and reads in that state return zero.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, every register reads as zero: mode, address bytes, count bytes and status. The data port read value is also zero.
- R2: The register offsets are as follows. 1 and 2 hold the low and high bytes of the current address. 3 and 4 hold the low and high bytes of the remaining count. 0 holds the mode in bits [1:0]. 5 holds the status. A register write is read back at once, and the address and count registers always read back their live values.
- R3: In remote write mode (mode code 2), with a non-zero count, a data-port write stores the byte at memory index (address mod BUF_BYTES). The 16-bit address then increments by one.
- R4: Every data-port access that takes effect decrements the remaining count by exactly one.
- R5: In remote read mode (mode code 1), with a non-zero count, a data-port read returns the byte at the current memory index on dp_rdata one clock after the strobe. The address then increments by one.
- R6: The completion flag is status bit 6. It is set in the cycle after an access takes the remaining count from one to zero.
- R7: Writing a status byte with bit 6 at one clears the completion flag. Writing a status byte with bit 6 at zero leaves the flag unchanged.
- R8: In the following cases a data-port access leaves memory, address and count unchanged, and a read strobe returns zero: mode code 0 or 3 (no DMA), a write strobe in read mode, a read strobe in write mode, or a remaining count of zero.
- R9: A transfer may start at any byte offset within a page. The high address byte selects the page and the low byte selects the offset, so page 3 offset 4 is memory index 0x304.
- R10: The memory index wraps modulo BUF_BYTES. A write at index BUF_BYTES-1 followed by another write places the second byte at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| dp_rd | input | 1 | Data-port read strobe, one byte per high cycle |
| dp_wr | input | 1 | Data-port write strobe, one byte per high cycle |
| dp_wdata | input | 8 | Data-port write byte |
| dp_rdata | output | 8 | Data-port read byte, registered |

## Verification
Register writes, address and count steps, and the completion flag all take effect at the clock edge that samples the strobe. Register readback is combinational, so each of these results is visible on reg_rdata in the same low clock phase that follows that edge. A data-port read passes through the registered memory output, so its byte is valid on dp_rdata after that same single edge and holds until the next read strobe. The bench changes inputs only on falling edges, holds each strobe for exactly one cycle, and samples results on the following falling edge. Every expected value is therefore checked exactly one edge after the stimulus that produced it.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 16;
   localparam int BYTE_W = 8;
   localparam int DONE_BIT = 6;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_READ  = 2'd1,
      MODE_WRITE = 2'd2,
      MODE_RSVD  = 2'd3
   } xfer_mode_t;

   localparam logic [2:0] OFS_MODE   = 3'd0;
   localparam logic [2:0] OFS_ADR_LO = 3'd1;
   localparam logic [2:0] OFS_ADR_HI = 3'd2;
   localparam logic [2:0] OFS_CNT_LO = 3'd3;
   localparam logic [2:0] OFS_CNT_HI = 3'd4;
   localparam logic [2:0] OFS_STAT   = 3'd5;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
   import rdma_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [2:0]          reg_addr,
   input  logic [BYTE_W-1:0]   reg_wdata,
   output logic [BYTE_W-1:0]   reg_rdata,
   input  logic                dp_rd,
   input  logic                dp_wr,
   output logic                go_rd,
   output logic                go_wr,
   output logic [ADDR_W-1:0]   cur_addr
);
   xfer_mode_t         mode_q;
   logic [CNT_W-1:0]   remain_q;
   logic               done_q;
   logic               step;
   logic               cnt_wr;
   logic               adr_wr;
   logic               done_set;
   logic               done_clr;

   assign go_rd    = dp_rd && (mode_q == MODE_READ)  && (remain_q != '0);
   assign go_wr    = dp_wr && (mode_q == MODE_WRITE) && (remain_q != '0);
   assign step     = go_rd || go_wr;
   assign cnt_wr   = reg_wr && (reg_addr == OFS_CNT_LO || reg_addr == OFS_CNT_HI);
   assign adr_wr   = reg_wr && (reg_addr == OFS_ADR_LO || reg_addr == OFS_ADR_HI);
   assign done_set = step && (remain_q == CNT_W'(1)) && !cnt_wr;
   assign done_clr = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[DONE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_IDLE;
         cur_addr <= '0;
         remain_q <= '0;
         done_q   <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == OFS_MODE)
            mode_q <= xfer_mode_t'(reg_wdata[1:0]);

         if (adr_wr) begin
            if (reg_addr == OFS_ADR_LO) cur_addr[7:0]  <= reg_wdata;
            else                        cur_addr[15:8] <= reg_wdata;
         end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
         end

         if (cnt_wr) begin
            if (reg_addr == OFS_CNT_LO) remain_q[7:0]  <= reg_wdata;
            else                        remain_q[15:8] <= reg_wdata;
         end else if (step) begin
            remain_q <= remain_q - 1'b1;
         end

         done_q <= done_set || (done_q && !done_clr);
      end
   end

   always_comb begin
      unique case (reg_addr)
         OFS_MODE:   reg_rdata = {6'b0, mode_q};
         OFS_ADR_LO: reg_rdata = cur_addr[7:0];
         OFS_ADR_HI: reg_rdata = cur_addr[15:8];
         OFS_CNT_LO: reg_rdata = remain_q[7:0];
         OFS_CNT_HI: reg_rdata = remain_q[15:8];
         OFS_STAT:   reg_rdata = {1'b0, done_q, 6'b0};
         default:    reg_rdata = '0;
      endcase
   end

   // R4: each effective access lowers the remaining count by one
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_wr) |=> (remain_q == $past(remain_q) - 1'b1));

   // R6: the flag rises after the last byte
   a_r6_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_wr && remain_q == CNT_W'(1)) |=> done_q);

   // R7: a write of one to the flag bit clears it
   a_r7_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr && !(step && remain_q == CNT_W'(1))) |=> !done_q);

   // R8: ignored accesses leave address and count untouched
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !reg_wr) |=> ($stable(cur_addr) && $stable(remain_q)));
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf
   import rdma_pkg::*;
#(
   parameter int DEPTH = 2048
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic                       re,
   input  logic                       rd_strobe,
   input  logic [$clog2(DEPTH)-1:0]   idx,
   input  logic [BYTE_W-1:0]          wdata,
   output logic [BYTE_W-1:0]          rdata
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if ((1 << IDX_W) != DEPTH || IDX_W < 8 || IDX_W > ADDR_W) begin : g_bad_depth
         $error("DEPTH must be a power of two from 256 to 65536");
      end
   endgenerate

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         rdata <= '0;
      else if (re)        rdata <= mem[idx];
      else if (rd_strobe) rdata <= '0;
   end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
   import rdma_pkg::*;
#(
   parameter int BUF_BYTES = 2048
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        dp_rd,
   input  logic        dp_wr,
   input  logic [7:0]  dp_wdata,
   output logic [7:0]  dp_rdata
);
   localparam int IDX_W = $clog2(BUF_BYTES);

   logic              go_rd;
   logic              go_wr;
   logic [ADDR_W-1:0] cur_addr;
   logic [IDX_W-1:0]  mem_idx;

   rdma_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .dp_rd     (dp_rd),
      .dp_wr     (dp_wr),
      .go_rd     (go_rd),
      .go_wr     (go_wr),
      .cur_addr  (cur_addr)
   );

   generate
      if (IDX_W < ADDR_W) begin : g_fold
         assign mem_idx = cur_addr[IDX_W-1:0];
      end else begin : g_full
         assign mem_idx = cur_addr;
      end
   endgenerate

   rdma_buf #(.DEPTH(BUF_BYTES)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (go_wr),
      .re        (go_rd),
      .rd_strobe (dp_rd),
      .idx       (mem_idx),
      .wdata     (dp_wdata),
      .rdata     (dp_rdata)
   );

   // R8: a read strobe that does not take effect yields zero
   a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rd && !go_rd) |=> (dp_rdata == 8'h00));

   // R5: read data only changes on a read strobe
   a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!dp_rd) |=> $stable(dp_rdata));
endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb;
   localparam int BUF = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       dp_rd = 1'b0;
   logic       dp_wr = 1'b0;
   logic [7:0] dp_wdata = 8'd0;
   logic [7:0] dp_rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rdma_port_engine #(.BUF_BYTES(BUF)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
      .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic read16(input logic [2:0] lo, output logic [15:0] v);
      logic [7:0] l, h;
      rreg(lo, l);
      rreg(lo + 3'd1, h);
      v = {h, l};
   endtask

   task automatic arm(input logic [1:0] mode, input logic [15:0] adr, input logic [15:0] cnt);
      wreg(3'd0, {6'b0, mode});
      wreg(3'd1, adr[7:0]);
      wreg(3'd2, adr[15:8]);
      wreg(3'd3, cnt[7:0]);
      wreg(3'd4, cnt[15:8]);
   endtask

   task automatic pwr(input logic [7:0] d);
      @(negedge clk);
      dp_wr = 1'b1; dp_wdata = d;
      @(negedge clk);
      dp_wr = 1'b0;
   endtask

   task automatic prd(output logic [7:0] d);
      @(negedge clk);
      dp_rd = 1'b1;
      @(negedge clk);
      dp_rd = 1'b0;
      d = dp_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int i = 0; i < 6; i++) begin
         rreg(3'(i), v);
         check("R1 reset reg", {8'h0, v}, 16'h0);
      end
      check("R1 reset dp_rdata", {8'h0, dp_rdata}, 16'h0);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      logic [7:0]  m;
      arm(2'd1, 16'h1234, 16'h0056);
      read16(3'd1, v); check("R2 address readback", v, 16'h1234);
      read16(3'd3, v); check("R2 count readback", v, 16'h0056);
      rreg(3'd0, m);   check("R2 mode readback", {8'h0, m}, 16'h0001);
   endtask

   task automatic t_write_read();
      logic [15:0] v;
      logic [7:0]  b;
      arm(2'd2, 16'h0304, 16'd4);
      for (int i = 0; i < 4; i++) begin
         pwr(8'hA0 + 8'(i));
         read16(3'd1, v); check("R3 address step on write", v, 16'h0305 + 16'(i));
         read16(3'd3, v); check("R4 count step", v, 16'(3 - i));
      end
      rreg(3'd5, b); check("R6 done after last byte", {8'h0, b}, 16'h0040);
      wreg(3'd5, 8'h00);
      rreg(3'd5, b); check("R7 zero write keeps flag", {8'h0, b}, 16'h0040);
      wreg(3'd5, 8'h40);
      rreg(3'd5, b); check("R7 one write clears flag", {8'h0, b}, 16'h0000);
      pwr(8'hEE);
      read16(3'd1, v); check("R8 zero count write ignored", v, 16'h0308);
      arm(2'd1, 16'h0304, 16'd4);
      for (int i = 0; i < 4; i++) begin
         prd(b);
         check("R5 R9 read at page offset", {8'h0, b}, {8'h0, 8'hA0 + 8'(i)});
      end
      read16(3'd1, v); check("R5 address step on read", v, 16'h0308);
      rreg(3'd5, b); check("R6 done after read run", {8'h0, b}, 16'h0040);
      prd(b); check("R8 read after count zero", {8'h0, b}, 16'h0000);
      wreg(3'd5, 8'hFF);
   endtask

   task automatic t_idle();
      logic [15:0] v;
      logic [7:0]  b;
      arm(2'd0, 16'h0304, 16'd3);
      pwr(8'hFF);
      prd(b); check("R8 idle mode read zero", {8'h0, b}, 16'h0000);
      read16(3'd1, v); check("R8 idle address held", v, 16'h0304);
      read16(3'd3, v); check("R8 idle count held", v, 16'd3);
      wreg(3'd0, 8'h03);
      pwr(8'hFF);
      read16(3'd3, v); check("R8 reserved mode ignored", v, 16'd3);
      wreg(3'd0, 8'h01);
      pwr(8'hFF);
      read16(3'd3, v); check("R8 write strobe in read mode", v, 16'd3);
      prd(b); check("R8 memory unchanged", {8'h0, b}, 16'h00A0);
      rreg(3'd5, b); check("R6 no flag before zero", {8'h0, b}, 16'h0000);
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      logic [7:0]  b;
      arm(2'd2, 16'(BUF - 1), 16'd2);
      pwr(8'h5A);
      pwr(8'hC3);
      read16(3'd1, v); check("R10 address after wrap", v, 16'(BUF + 1));
      arm(2'd1, 16'h0000, 16'd1);
      prd(b); check("R10 second byte at index 0", {8'h0, b}, 16'h00C3);
      arm(2'd1, 16'(BUF - 1), 16'd1);
      prd(b); check("R10 first byte at top", {8'h0, b}, 16'h005A);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_write_read();
      t_idle();
      t_wrap();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule